// File: doc/BRIEF.md
# Vector Byte Variable Right Shifter

This unit takes two 128-bit operands, A and B, and treats each of them as sixteen byte lanes. Every lane of the result is A's byte in that lane shifted right by a per-lane amount. The amount comes from the low three bits of the matching byte of B. The bits that move into the top of a lane come from the next more-significant byte of A, so each lane is a funnel shift across the byte boundary. Nothing can enter the most significant lane from above, so it fills with zeros.

An operation is issued by raising `in_valid` with both operands and a two-field opcode. Exactly one cycle later the result appears on a register together with `out_valid`. An unsupported opcode gives an all-zero result with `out_illegal` set. All lanes read the operands as they were presented, so the result is correct even when the destination of the operation is also one of its sources.

The output stage is a small state machine with three states. ST_IDLE means no result is being presented. ST_RESULT means a valid shifted vector is on the output. ST_FAULT means an illegal opcode was flagged. On each clock the next state is chosen from the input. With `in_valid` low the machine goes to ST_IDLE (transition "drain"). With `in_valid` high and a legal opcode it goes to ST_RESULT (transition "accept"). With `in_valid` high and an illegal opcode it goes to ST_FAULT (transition "reject"). These rules apply from every state. Reset forces ST_IDLE.

Top module: `lane_funnel_shr`

## Requirements
- R1: Lane 0 occupies bits 127:120 of every 128-bit bus and lane 15 occupies bits 7:0. Lane k occupies bits 127-8k down to 120-8k.
- R2: The shift amount for lane k is bits 2:0 of byte k of `opnd_b`, giving a range of 0 to 7. Bits 7:3 of that byte have no effect on the result.
- R3: For lane k > 0, result byte k is the low 8 bits of the 16-bit value {A byte k-1, A byte k} shifted right by the lane's amount.
- R4: For lane 0 the upper half of the 16-bit value is zero, so the top `amount` bits of result lane 0 are zero.
- R5: A lane whose amount is 0 returns A's byte in that lane unchanged.
- R6: Every result lane is computed from the operand A as presented, and no result byte feeds into another lane.
- R7: The operation is legal only when `op_major` equals 2 and `op_minor` equals 28.
- R8: `out_valid` is high exactly one clock after a cycle in which `in_valid` was sampled high, and low otherwise.
- R9: When an illegal opcode is issued, the next cycle shows `out_valid` high, `out_illegal` high and `out_data` all zero. A legal opcode shows `out_illegal` low.
- R10: Synchronous active-high reset clears `out_valid`, `out_illegal` and `out_data`.
- R11: While `in_valid` is low, `out_data` holds its last value and `out_illegal` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and opcode are presented this cycle |
| op_major | input | 4 | Opcode major field, legal value 2 |
| op_minor | input | 6 | Opcode minor field, legal value 28 |
| opnd_a | input | 128 | Data operand, sixteen byte lanes |
| opnd_b | input | 128 | Shift-amount operand, low 3 bits of each byte used |
| out_valid | output | 1 | Registered result is valid |
| out_illegal | output | 1 | The issued opcode was unsupported |
| out_data | output | 128 | Registered shifted vector |

## Verification
The clocked properties assume that `in_valid`, the opcode fields and the operands are driven from known values. They also assume that reset is held for at least one edge before the first operation, because the lane-0 and hold checks compare against values captured on the previous edge. The bench changes every input only on the falling clock edge and releases reset before it issues anything. It also changes the operands during cycles with `in_valid` low, so that the hold property and the "no effect" requirements are exercised with real input activity.

// File: rtl/vbrs_pkg.sv
package vbrs_pkg;
    localparam int DATA_W  = 128;
    localparam int LANE_W  = 8;
    localparam int AMT_W   = 3;
    localparam int LANES   = DATA_W / LANE_W;
    localparam int MAJ_W   = 4;
    localparam int MIN_W   = 6;
    localparam logic [MAJ_W-1:0] OP_MAJOR_SHR = 4'd2;
    localparam logic [MIN_W-1:0] OP_MINOR_SHR = 6'd28;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RESULT = 2'd1,
        ST_FAULT  = 2'd2
    } out_state_t;
endpackage

// File: rtl/vbrs_lane.sv
module vbrs_lane #(
    parameter int LW = 8,
    parameter int SW = 3
) (
    input  logic [LW-1:0] hi_byte,
    input  logic [LW-1:0] cur_byte,
    input  logic [SW-1:0] amt,
    output logic [LW-1:0] lane_out
);
    localparam int PAIR_W = 2 * LW;

    logic [PAIR_W-1:0] pair;
    logic [PAIR_W-1:0] shifted;

    always_comb begin
        pair     = {hi_byte, cur_byte};
        shifted  = pair >> amt;
        lane_out = shifted[LW-1:0];
    end

    // R5: an amount of zero must pass the lane byte through untouched
    always_comb begin
        if (amt == '0) begin
            a_r5_zero_pass: assert (lane_out == cur_byte);
        end
    end
endmodule

// File: rtl/vbrs_decode.sv
module vbrs_decode #(
    parameter int MW = 4,
    parameter int NW = 6,
    parameter logic [MW-1:0] MATCH_MAJ = 4'd2,
    parameter logic [NW-1:0] MATCH_MIN = 6'd28
) (
    input  logic [MW-1:0] op_major,
    input  logic [NW-1:0] op_minor,
    output logic          op_ok
);
    always_comb begin
        op_ok = (op_major == MATCH_MAJ) && (op_minor == MATCH_MIN);
    end
endmodule

// File: rtl/vbrs_out_stage.sv
module vbrs_out_stage
    import vbrs_pkg::*;
#(
    parameter int DW = 128
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic          op_ok,
    input  logic [DW-1:0] lanes_in,
    output logic          out_valid,
    output logic          out_illegal,
    output logic [DW-1:0] out_data
);
    out_state_t state_q, state_d;
    logic [DW-1:0] data_q;

    always_comb begin
        unique case ({in_valid, op_ok})
            2'b11:   state_d = ST_RESULT;
            2'b10:   state_d = ST_FAULT;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
        end else if (in_valid) begin
            data_q <= op_ok ? lanes_in : '0;
        end
    end

    always_comb begin
        out_valid   = 1'b0;
        out_illegal = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_RESULT: out_valid = 1'b1;
            ST_FAULT: begin
                out_valid   = 1'b1;
                out_illegal = 1'b1;
            end
            default: ;
        endcase
        out_data = data_q;
    end

    // R8: valid follows the sampled input valid by exactly one edge
    a_r8_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r8_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    // R9: a flagged illegal op presents a zero vector with valid
    a_r9_illegal_zero: assert property (@(posedge clk) disable iff (rst)
        out_illegal |-> (out_valid && out_data == '0));
    a_r9_flag_on_bad_op: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !op_ok) |=> out_illegal);
    // R11: no new issue means the result register holds
    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_data) && !out_illegal));
endmodule

// File: rtl/lane_funnel_shr.sv
module lane_funnel_shr
    import vbrs_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [MAJ_W-1:0]   op_major,
    input  logic [MIN_W-1:0]   op_minor,
    input  logic [DATA_W-1:0]  opnd_a,
    input  logic [DATA_W-1:0]  opnd_b,
    output logic               out_valid,
    output logic               out_illegal,
    output logic [DATA_W-1:0]  out_data
);
    localparam int UPPER_W = LANE_W - AMT_W;

    logic              op_ok;
    logic [DATA_W-1:0] lanes_res;
    logic [LANES-1:0]  unused_b_upper;

    vbrs_decode #(
        .MW(MAJ_W), .NW(MIN_W),
        .MATCH_MAJ(OP_MAJOR_SHR), .MATCH_MIN(OP_MINOR_SHR)
    ) u_decode (
        .op_major(op_major),
        .op_minor(op_minor),
        .op_ok(op_ok)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        localparam int LO = DATA_W - LANE_W * (k + 1);
        logic [LANE_W-1:0] hi_src;
        if (k == 0) begin : g_edge
            assign hi_src = '0;
        end else begin : g_inner
            assign hi_src = opnd_a[LO + LANE_W +: LANE_W];
        end
        assign unused_b_upper[k] = ^opnd_b[LO + AMT_W +: UPPER_W];

        vbrs_lane #(.LW(LANE_W), .SW(AMT_W)) u_lane (
            .hi_byte(hi_src),
            .cur_byte(opnd_a[LO +: LANE_W]),
            .amt(opnd_b[LO +: AMT_W]),
            .lane_out(lanes_res[LO +: LANE_W])
        );
    end

    vbrs_out_stage #(.DW(DATA_W)) u_out (
        .clk(clk),
        .rst(rst),
        .in_valid(in_valid),
        .op_ok(op_ok),
        .lanes_in(lanes_res),
        .out_valid(out_valid),
        .out_illegal(out_illegal),
        .out_data(out_data)
    );

    // R4: lane 0 receives only zeros from above its boundary
    logic [AMT_W-1:0] lane0_amt_q;
    always_ff @(posedge clk) begin
        if (rst)           lane0_amt_q <= '0;
        else if (in_valid) lane0_amt_q <= opnd_b[DATA_W-LANE_W +: AMT_W];
    end

    a_r4_lane0_fill: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_illegal) |->
        ((out_data[DATA_W-1 -: LANE_W] & ~(8'hFF >> lane0_amt_q)) == 8'h00));
endmodule

// File: tb/lane_funnel_shr_tb.sv
module lane_funnel_shr_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 4;

    // each entry: {A, B, expected}
    localparam logic [383:0] VEC [NVEC] = '{
        {128'h00112233445566778899AABBCCDDEEFF, 128'h0, 128'h00112233445566778899AABBCCDDEEFF},
        {{16{8'hFF}}, {16{8'h01}}, {8'h7F, {15{8'hFF}}}},
        {{16{8'hFF}}, {16{8'hF8}}, {16{8'hFF}}},
        {{8'h01, 120'h0}, {16{8'h07}}, {8'h00, 8'h02, 112'h0}}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [3:0]   op_major = 4'd2;
    logic [5:0]   op_minor = 6'd28;
    logic [127:0] opnd_a = '0;
    logic [127:0] opnd_b = '0;
    logic         out_valid;
    logic         out_illegal;
    logic [127:0] out_data;

    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lane_funnel_shr u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .op_major(op_major), .op_minor(op_minor),
        .opnd_a(opnd_a), .opnd_b(opnd_b),
        .out_valid(out_valid), .out_illegal(out_illegal), .out_data(out_data)
    );

    function automatic logic [127:0] model(input logic [127:0] a, input logic [127:0] b);
        logic [127:0] r;
        for (int k = 0; k < 16; k++) begin
            logic [7:0]  cur;
            logic [7:0]  hi;
            logic [2:0]  s;
            logic [15:0] p;
            cur = a[127-8*k -: 8];
            hi  = (k == 0) ? 8'h00 : a[135-8*k -: 8];
            s   = b[122-8*k -: 3];
            p   = {hi, cur} >> s;
            r[127-8*k -: 8] = p[7:0];
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [127:0] got, input logic [127:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic issue(input logic [127:0] a, input logic [127:0] b,
                         input logic [3:0] maj, input logic [5:0] mnr);
        @(negedge clk);
        opnd_a = a; opnd_b = b; op_major = maj; op_minor = mnr; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 100000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : main
        logic [127:0] a, b, keep;
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10 valid", {127'h0, out_valid}, 128'h0);
        check("R10 illegal", {127'h0, out_illegal}, 128'h0);
        check("R10 data", out_data, 128'h0);
        rst = 1'b0;

        // table walk: R1 R3 R4 R5 R2
        for (int v = 0; v < NVEC; v++) begin
            issue(VEC[v][383:256], VEC[v][255:128], 4'd2, 6'd28);
            check("R1/R3 table", out_data, VEC[v][127:0]);
            check("R8 valid", {127'h0, out_valid}, 128'h1);
        end

        // R5 and R3: every shift amount 0..7 in all lanes, R2 upper bits set
        for (int s = 0; s < 8; s++) begin
            a = {$urandom, $urandom, $urandom, $urandom};
            b = {16{5'b10110, s[2:0]}};
            issue(a, b, 4'd2, 6'd28);
            check("R2/R3 amount sweep", out_data, model(a, b));
            if (s == 0) check("R5 zero shift", out_data, a);
            check("R4 lane0 fill", {120'h0, out_data[127:120]}, {120'h0, 8'(a[127:120] >> s)});
        end

        // R6: random operands, each lane from original A
        for (int n = 0; n < 200; n++) begin
            a = {$urandom, $urandom, $urandom, $urandom};
            b = {$urandom, $urandom, $urandom, $urandom};
            issue(a, b, 4'd2, 6'd28);
            check("R6 random", out_data, model(a, b));
            check("R9 legal flag", {127'h0, out_illegal}, 128'h0);
        end

        // R2: upper bits alone differ, same result
        a = 128'hDEADBEEF0123456789ABCDEF55AA33CC;
        issue(a, {16{8'h05}}, 4'd2, 6'd28);
        keep = out_data;
        issue(a, {16{8'hFD}}, 4'd2, 6'd28);
        check("R2 upper bits ignored", out_data, keep);

        // R11: hold while idle, inputs toggling
        @(negedge clk);
        opnd_a = ~a; opnd_b = 128'h0707;
        @(negedge clk);
        check("R11 hold data", out_data, keep);
        check("R8 idle valid", {127'h0, out_valid}, 128'h0);
        check("R11 idle illegal", {127'h0, out_illegal}, 128'h0);

        // R7 / R9: illegal encodings
        issue(a, 128'h0, 4'd3, 6'd28);
        check("R9 bad major data", out_data, 128'h0);
        check("R9 bad major flag", {126'h0, out_valid, out_illegal}, 128'h3);
        issue(a, 128'h0, 4'd2, 6'd29);
        check("R7 bad minor flag", {126'h0, out_valid, out_illegal}, 128'h3);
        issue(a, 128'h0, 4'd2, 6'd28);
        check("R7 legal again", out_data, a);
        check("R7 legal flag", {126'h0, out_valid, out_illegal}, 128'h2);

        // R10: reset mid-stream
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b1;
        @(negedge clk);
        check("R10 reset data", out_data, 128'h0);
        check("R10 reset valid", {127'h0, out_valid}, 128'h0);
        rst = 1'b0; in_valid = 1'b0;

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule